// File: doc/BRIEF.md
# Reduced-pin Ethernet MAC rate adapter

This block sits between a MAC that exchanges 4-bit nibbles and a PHY that uses the reduced two-bit interface. Both sides run from one 50 MHz reference clock. Nibbles are handed over by one-cycle strobes on the MAC side, so no MII-style transmit or receive clock is needed. On transmit, each nibble leaves as two dibits. On receive, the combined carrier/data-valid line and the two receive data bits are sampled, and the dibits are paired back into nibbles. The recovered carrier is kept apart from data valid.

Speed and duplex come from configuration inputs that management firmware sets. At 100 Mbit/s every reference cycle carries one dibit. At 10 Mbit/s one cycle in ten is used: transmit values are held for ten cycles and receive inputs are read once per ten cycles. The reduced interface has no collision pin. In half duplex the block therefore makes its own collision indication from its transmit enable and the recovered carrier. A speed change seen in the middle of a frame waits until both directions are idle.

Top module: `rmii_mac_bridge`

## Requirements
- R1: While `rst_n` is low at a clock edge, all registered outputs go to 0 (`phy_tx_dibit`, `phy_tx_valid`, `mac_rx_nib`, `mac_rx_valid`, `mac_carrier`, `mac_rx_pulse`). The active speed returns to 100 Mbit/s.
- R2: At 100 Mbit/s, `mac_tx_take` is high in the cycle in which the nibble is sampled, which is every second cycle. The sampled nibble appears on `phy_tx_dibit` as bits [1:0] in the next cycle and bits [3:2] in the cycle after, with `phy_tx_valid` high for both. A nibble sampled with `mac_tx_active` low ends the frame: `phy_tx_valid` drops and `phy_tx_dibit` goes to 0.
- R3: At 10 Mbit/s, `phy_tx_dibit` and `phy_tx_valid` change only once per 10 cycles, so each dibit is held for 10 cycles and `mac_tx_take` pulses once every 20 cycles.
- R4: At 100 Mbit/s, a high `phy_rx_cdv` sampled while receive is idle starts a frame, and that dibit is the low half of the first nibble. Each following pair of samples gives one nibble {second, first}. `mac_rx_nib` and `mac_rx_valid` are updated one cycle after the second sample, and `mac_rx_pulse` is high for exactly that cycle.
- R5: At 10 Mbit/s, receive inputs are sampled once per 10 cycles. Values present on the other nine cycles have no effect on any output.
- R6: A nibble whose two `phy_rx_cdv` samples are both low ends the frame. `mac_rx_valid` falls, `mac_rx_nib` goes to 0, and `mac_rx_pulse` still pulses for that nibble.
- R7: `mac_carrier` rises with the first sample of a frame. It falls at the first low sample of `phy_rx_cdv` in the frame and stays low until the frame ends, even when later samples are high. During that time, nibbles with one high sample are still delivered with `mac_rx_valid` high.
- R8: With `cfg_fdx` low, `mac_collide` equals `phy_tx_valid` AND `mac_carrier`.
- R9: With `cfg_fdx` high, `mac_collide` stays low.
- R10: A change on `cfg_slow` takes effect only in a cycle in which neither a transmit frame (`phy_tx_valid` high) nor a receive frame is in progress. No sample is taken in the switching cycle, and the 10 Mbit/s divider restarts there.
- R11: The block's own transmission never raises `mac_carrier`. Carrier reflects receive activity only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_slow | input | 1 | Speed setting: 1 = 10 Mbit/s, 0 = 100 Mbit/s |
| cfg_fdx | input | 1 | Duplex setting: 1 = full duplex |
| mac_tx_nib | input | 4 | Transmit nibble from the MAC |
| mac_tx_active | input | 1 | MAC frame in progress, qualifies `mac_tx_nib` |
| mac_tx_take | output | 1 | Nibble and enable are sampled at the end of this cycle |
| mac_rx_nib | output | 4 | Assembled receive nibble |
| mac_rx_valid | output | 1 | Receive data valid |
| mac_carrier | output | 1 | Recovered receive carrier |
| mac_collide | output | 1 | Synthesized collision indication |
| mac_rx_pulse | output | 1 | One-cycle pulse when a receive nibble is updated |
| phy_tx_dibit | output | 2 | Transmit dibit to the PHY |
| phy_tx_valid | output | 1 | Transmit enable to the PHY |
| phy_rx_dibit | input | 2 | Receive dibit from the PHY |
| phy_rx_cdv | input | 1 | Combined carrier/data-valid from the PHY |

## Verification
The hold and sampling properties assume that the MAC presents each transmit nibble before the cycle in which `mac_tx_take` is high. They also assume that configuration may change in any cycle, so a switch can be requested in the middle of a frame. The stimulus feeds the next nibble only in a cycle in which a take is expected, and it changes `cfg_slow` while a transmit frame is running. At 10 Mbit/s it drives random values on the receive pins in every cycle that is not a sampling cycle. Receive frames end with alternating carrier samples before two low samples, which exercises the carrier-lost and end-of-frame rules.

// File: rtl/rmb_pkg.sv
// Shared constants and types for the reduced-pin MAC rate adapter.
package rmb_pkg;
    localparam int unsigned NIB_W        = 4;
    localparam int unsigned DIB_W        = 2;
    localparam int unsigned SLOW_DIV_DEF = 10;

    // Which half of a nibble the next dibit belongs to.
    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;
endpackage

// File: rtl/rmb_pace.sv
// Sample pacing: produces the per-cycle sampling enable and holds the
// active speed. Assumes `idle` is high only when no frame is in flight in
// either direction; a pending speed change is applied in such a cycle and
// that cycle carries no sample.
module rmb_pace #(
    parameter int unsigned SLOW_DIV = rmb_pkg::SLOW_DIV_DEF
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_slow,
    input  logic idle,
    output logic tick,
    output logic slow_act
);
    localparam int unsigned CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic swap;
    logic slot;

    assign swap = idle && (cfg_slow != slow_act);
    assign tick = !swap && (!slow_act || slot);

    // Latch the requested speed only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slow_act <= 1'b0;
        end else if (swap) begin
            slow_act <= cfg_slow;
        end
    end

    generate
        if (SLOW_DIV > 1) begin : g_div
            localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SLOW_DIV - 1);
            logic [CNT_W-1:0] cnt;

            // Count reference cycles between slow-speed samples.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (swap || !slow_act || (cnt == CNT_LAST)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign slot = (cnt == CNT_LAST);
        end else begin : g_nodiv
            assign slot = 1'b1;
        end
    endgenerate

    // R10: the active speed never moves while a frame is in flight.
    p_speed_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(idle) |-> $stable(slow_act));
endmodule

// File: rtl/rmb_tx.sv
// Transmit splitter: takes one nibble from the MAC on each even sampling
// slot and drives it as two dibits, low-order pair first. Assumes the MAC
// holds its nibble and enable valid through the cycle that `mac_tx_take`
// marks.
module rmb_tx
    import rmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [NIB_W-1:0] mac_tx_nib,
    input  logic             mac_tx_active,
    output logic             mac_tx_take,
    output logic [DIB_W-1:0] phy_tx_dibit,
    output logic             phy_tx_valid
);
    half_e            half;
    logic [DIB_W-1:0] upper;

    assign mac_tx_take = tick && (half == HALF_LO);

    // Emit the low dibit on take, the stored high dibit on the next slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half         <= HALF_LO;
            upper        <= '0;
            phy_tx_dibit <= '0;
            phy_tx_valid <= 1'b0;
        end else if (tick) begin
            if (half == HALF_HI) begin
                phy_tx_dibit <= upper;
                half         <= HALF_LO;
            end else if (mac_tx_active) begin
                phy_tx_dibit <= mac_tx_nib[DIB_W-1:0];
                upper        <= mac_tx_nib[NIB_W-1:DIB_W];
                phy_tx_valid <= 1'b1;
                half         <= HALF_HI;
            end else begin
                phy_tx_dibit <= '0;
                phy_tx_valid <= 1'b0;
            end
        end
    end

    // R2: the second half of a nibble is always sent with enable high.
    p_tx_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (half == HALF_HI) |-> phy_tx_valid);
endmodule

// File: rtl/rmb_rx.sv
// Receive assembler: pairs sampled dibits into nibbles, keeps carrier apart
// from data valid, and closes the frame when both samples of a nibble show
// the carrier/data-valid line low. Assumes the PHY starts a frame on a
// nibble boundary.
module rmb_rx
    import rmb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [DIB_W-1:0] phy_rx_dibit,
    input  logic             phy_rx_cdv,
    output logic [NIB_W-1:0] mac_rx_nib,
    output logic             mac_rx_valid,
    output logic             mac_carrier,
    output logic             mac_rx_pulse,
    output logic             rx_busy
);
    half_e            half;
    logic             in_frame;
    logic [DIB_W-1:0] low_d;
    logic             low_cv;

    assign rx_busy = in_frame;

    // Sample on each slot, assemble nibbles and track carrier and valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half         <= HALF_LO;
            in_frame     <= 1'b0;
            low_d        <= '0;
            low_cv       <= 1'b0;
            mac_rx_nib   <= '0;
            mac_rx_valid <= 1'b0;
            mac_carrier  <= 1'b0;
            mac_rx_pulse <= 1'b0;
        end else begin
            mac_rx_pulse <= 1'b0;
            if (tick) begin
                if (!in_frame) begin
                    if (phy_rx_cdv) begin
                        in_frame    <= 1'b1;
                        mac_carrier <= 1'b1;
                        low_d       <= phy_rx_dibit;
                        low_cv      <= 1'b1;
                        half        <= HALF_HI;
                    end
                end else if (half == HALF_LO) begin
                    low_d  <= phy_rx_dibit;
                    low_cv <= phy_rx_cdv;
                    half   <= HALF_HI;
                    if (!phy_rx_cdv) begin
                        mac_carrier <= 1'b0;
                    end
                end else begin
                    half         <= HALF_LO;
                    mac_rx_pulse <= 1'b1;
                    if (low_cv || phy_rx_cdv) begin
                        mac_rx_nib   <= {phy_rx_dibit, low_d};
                        mac_rx_valid <= 1'b1;
                        if (!phy_rx_cdv) begin
                            mac_carrier <= 1'b0;
                        end
                    end else begin
                        mac_rx_nib   <= '0;
                        mac_rx_valid <= 1'b0;
                        in_frame     <= 1'b0;
                        mac_carrier  <= 1'b0;
                    end
                end
            end
        end
    end

    // R5: receive outputs move only after a sampling slot.
    p_rx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(mac_rx_nib) && $stable(mac_rx_valid) && $stable(mac_carrier)));

    // R4: the nibble pulse lasts exactly one cycle.
    p_rx_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mac_rx_pulse |=> !mac_rx_pulse);
endmodule

// File: rtl/rmii_mac_bridge.sv
// Top of the rate adapter: joins pacing, transmit splitting and receive
// assembly, and derives the collision indication in half duplex. Assumes
// one reference clock for both sides and configuration set by management.
module rmii_mac_bridge
    import rmb_pkg::*;
#(
    parameter int unsigned SLOW_DIV = SLOW_DIV_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_slow,
    input  logic             cfg_fdx,
    input  logic [NIB_W-1:0] mac_tx_nib,
    input  logic             mac_tx_active,
    output logic             mac_tx_take,
    output logic [NIB_W-1:0] mac_rx_nib,
    output logic             mac_rx_valid,
    output logic             mac_carrier,
    output logic             mac_collide,
    output logic             mac_rx_pulse,
    output logic [DIB_W-1:0] phy_tx_dibit,
    output logic             phy_tx_valid,
    input  logic [DIB_W-1:0] phy_rx_dibit,
    input  logic             phy_rx_cdv
);
    logic tick;
    logic slow_act;
    logic rx_busy;
    logic idle;

    assign idle = !phy_tx_valid && !rx_busy;

    rmb_pace #(.SLOW_DIV(SLOW_DIV)) u_pace (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_slow (cfg_slow),
        .idle     (idle),
        .tick     (tick),
        .slow_act (slow_act)
    );

    rmb_tx u_tx (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .mac_tx_nib    (mac_tx_nib),
        .mac_tx_active (mac_tx_active),
        .mac_tx_take   (mac_tx_take),
        .phy_tx_dibit  (phy_tx_dibit),
        .phy_tx_valid  (phy_tx_valid)
    );

    rmb_rx u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .phy_rx_dibit (phy_rx_dibit),
        .phy_rx_cdv   (phy_rx_cdv),
        .mac_rx_nib   (mac_rx_nib),
        .mac_rx_valid (mac_rx_valid),
        .mac_carrier  (mac_carrier),
        .mac_rx_pulse (mac_rx_pulse),
        .rx_busy      (rx_busy)
    );

    // Collision: own transmission overlapping received carrier, half duplex.
    assign mac_collide = !cfg_fdx && phy_tx_valid && mac_carrier;

    // R3: transmit pins change only after a sampling slot.
    p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(tick) |-> ($stable(phy_tx_dibit) && $stable(phy_tx_valid)));

    // R3: at slow speed two takes are never adjacent.
    p_take_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_act && mac_tx_take) |=> !mac_tx_take);

    // R9: full duplex keeps collision quiet.
    p_fdx_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_fdx |-> !mac_collide);

    // R8: a collision needs own transmission on the pins.
    p_col_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mac_collide |-> phy_tx_valid);
endmodule

// File: tb/rmii_mac_bridge_bench.sv
// Bench: behavioural reference model updated on every clock and compared
// with all outputs each cycle, plus directed checks at scenario ends.
module rmii_mac_bridge_bench;
    localparam int DIV = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_slow = 1'b0;
    logic       cfg_fdx = 1'b0;
    logic [3:0] mac_tx_nib = '0;
    logic       mac_tx_active = 1'b0;
    logic       mac_tx_take;
    logic [3:0] mac_rx_nib;
    logic       mac_rx_valid;
    logic       mac_carrier;
    logic       mac_collide;
    logic       mac_rx_pulse;
    logic [1:0] phy_tx_dibit;
    logic       phy_tx_valid;
    logic [1:0] phy_rx_dibit = '0;
    logic       phy_rx_cdv = 1'b0;

    rmii_mac_bridge #(.SLOW_DIV(DIV)) u_rmii_mac_bridge (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_slow      (cfg_slow),
        .cfg_fdx       (cfg_fdx),
        .mac_tx_nib    (mac_tx_nib),
        .mac_tx_active (mac_tx_active),
        .mac_tx_take   (mac_tx_take),
        .mac_rx_nib    (mac_rx_nib),
        .mac_rx_valid  (mac_rx_valid),
        .mac_carrier   (mac_carrier),
        .mac_collide   (mac_collide),
        .mac_rx_pulse  (mac_rx_pulse),
        .phy_tx_dibit  (phy_tx_dibit),
        .phy_tx_valid  (phy_tx_valid),
        .phy_rx_dibit  (phy_rx_dibit),
        .phy_rx_cdv    (phy_rx_cdv)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    int tx_q[$];
    int rx_q[$];
    int want_slow = 0;
    int want_fdx = 0;

    // Reference model state.
    int m_slow = 0, m_cnt = 0, m_tick = 0;
    int m_tph = 0, m_thi = 0, m_txd = 0, m_txv = 0;
    int m_inf = 0, m_rph = 0, m_lod = 0, m_locv = 0;
    int m_car = 0, m_nib = 0, m_dv = 0, m_pulse = 0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_slow = 0; m_cnt = 0; m_tph = 0; m_thi = 0; m_txd = 0; m_txv = 0;
        m_inf = 0; m_rph = 0; m_lod = 0; m_locv = 0; m_car = 0;
        m_nib = 0; m_dv = 0; m_pulse = 0;
    endtask

    function automatic int next_tick();
        int idle_now = (m_txv == 0 && m_inf == 0) ? 1 : 0;
        int sw = (idle_now == 1 && int'(cfg_slow) != m_slow) ? 1 : 0;
        if (sw == 1) return 0;
        return (m_slow == 0 || m_cnt == DIV - 1) ? 1 : 0;
    endfunction

    task automatic model_step();
        int idle_now = (m_txv == 0 && m_inf == 0) ? 1 : 0;
        int sw = (idle_now == 1 && int'(cfg_slow) != m_slow) ? 1 : 0;
        int tk = next_tick();
        int cv = int'(phy_rx_cdv);
        int d = int'(phy_rx_dibit);
        m_pulse = 0;
        if (tk == 1) begin
            if (m_tph == 1) begin
                m_txd = m_thi; m_tph = 0;
            end else if (mac_tx_active) begin
                m_txd = int'(mac_tx_nib) % 4; m_thi = int'(mac_tx_nib) / 4;
                m_txv = 1; m_tph = 1;
            end else begin
                m_txd = 0; m_txv = 0;
            end
            if (m_inf == 0) begin
                if (cv == 1) begin
                    m_inf = 1; m_car = 1; m_lod = d; m_locv = 1; m_rph = 1;
                end
            end else if (m_rph == 0) begin
                m_lod = d; m_locv = cv; m_rph = 1;
                if (cv == 0) m_car = 0;
            end else begin
                m_rph = 0; m_pulse = 1;
                if (m_locv == 1 || cv == 1) begin
                    m_nib = d * 4 + m_lod; m_dv = 1;
                    if (cv == 0) m_car = 0;
                end else begin
                    m_nib = 0; m_dv = 0; m_inf = 0; m_car = 0;
                end
            end
        end
        if (sw == 1) begin
            m_slow = int'(cfg_slow); m_cnt = 0;
        end else if (m_slow == 1) begin
            m_cnt = (m_cnt == DIV - 1) ? 0 : m_cnt + 1;
        end else begin
            m_cnt = 0;
        end
    endtask

    // Per clock: advance the model, drive the next inputs, compare outputs.
    always @(posedge clk) begin
        string ttag;
        string rtag;
        string ctag;
        string ltag;
        int take_exp;
        int v;
        if (!rst_n) model_reset();
        else model_step();
        #1;
        cfg_slow = want_slow[0];
        cfg_fdx = want_fdx[0];
        m_tick = next_tick();
        take_exp = (rst_n && m_tick == 1 && m_tph == 0) ? 1 : 0;
        if (take_exp == 1) begin
            if (tx_q.size() > 0) begin
                v = tx_q.pop_front();
                mac_tx_active = (v >= 0);
                mac_tx_nib = (v >= 0) ? v[3:0] : 4'h0;
            end else begin
                mac_tx_active = 1'b0;
            end
        end
        if (m_tick == 1) begin
            if (rx_q.size() > 0) begin
                v = rx_q.pop_front();
                phy_rx_cdv = v[2];
                phy_rx_dibit = v[1:0];
            end else begin
                phy_rx_cdv = 1'b0;
                phy_rx_dibit = 2'b00;
            end
        end else begin
            // R5: random values between sampling slots must be ignored.
            phy_rx_cdv = 1'($urandom);
            phy_rx_dibit = 2'($urandom);
        end
        #1;
        if (rst_n) begin
            ttag = (int'(cfg_slow) != m_slow) ? "R10" : ((m_slow == 1) ? "R3" : "R2");
            rtag = (m_slow == 1) ? "R5" : "R4";
            if (m_pulse == 1 && m_dv == 0) rtag = "R6";
            ctag = (m_inf == 0 && m_txv == 1) ? "R11" : "R7";
            ltag = cfg_fdx ? "R9" : "R8";
            chk(ttag, "phy_tx_dibit", int'(phy_tx_dibit), m_txd);
            chk(ttag, "phy_tx_valid", int'(phy_tx_valid), m_txv);
            chk(ttag, "mac_tx_take", int'(mac_tx_take), take_exp);
            chk(rtag, "mac_rx_valid", int'(mac_rx_valid), m_dv);
            chk(rtag, "mac_rx_nib", int'(mac_rx_nib), m_nib);
            chk(rtag, "mac_rx_pulse", int'(mac_rx_pulse), m_pulse);
            chk(ctag, "mac_carrier", int'(mac_carrier), m_car);
            chk(ltag, "mac_collide", int'(mac_collide),
                (cfg_fdx == 1'b0 && m_txv == 1 && m_car == 1) ? 1 : 0);
        end
    end

    task automatic push_tx(input int len, input int seed);
        for (int i = 0; i < len; i++) tx_q.push_back((seed + i * 5) % 16);
        tx_q.push_back(-1);
    endtask

    // Frame body, then a carrier-lost tail nibble, then the closing nibble.
    task automatic push_rx(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            int nib = (seed + i * 7) % 16;
            rx_q.push_back(4 + nib % 4);
            rx_q.push_back(4 + nib / 4);
        end
        rx_q.push_back(2);
        rx_q.push_back(4 + 1);
        rx_q.push_back(0);
        rx_q.push_back(0);
    endtask

    task automatic wait_idle();
        do begin
            @(posedge clk); #3;
        end while (tx_q.size() != 0 || rx_q.size() != 0 || m_txv != 0 ||
                   m_inf != 0 || want_slow != m_slow);
        repeat (4) @(posedge clk);
        #3;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state of the registered outputs.
        chk("R1", "phy_tx_dibit", int'(phy_tx_dibit), 0);
        chk("R1", "phy_tx_valid", int'(phy_tx_valid), 0);
        chk("R1", "mac_rx_nib", int'(mac_rx_nib), 0);
        chk("R1", "mac_rx_valid", int'(mac_rx_valid), 0);
        chk("R1", "mac_carrier", int'(mac_carrier), 0);
        chk("R1", "mac_rx_pulse", int'(mac_rx_pulse), 0);
        rst_n = 1'b1;

        // 100 Mbit/s half duplex with overlapping frames (collision).
        push_tx(6, 1);
        push_rx(5, 3);
        wait_idle();
        chk("R6", "mac_rx_valid after end", int'(mac_rx_valid), 0);
        chk("R6", "mac_rx_nib after end", int'(mac_rx_nib), 0);

        // Full duplex: same traffic, collision must stay low.
        want_fdx = 1;
        push_tx(6, 9);
        push_rx(5, 11);
        wait_idle();

        // Speed request raised in the middle of a transmit frame.
        want_fdx = 0;
        push_tx(8, 4);
        repeat (5) @(posedge clk);
        want_slow = 1;
        wait_idle();
        chk("R10", "slow speed active after idle", m_slow, 1);

        // 10 Mbit/s half duplex with collision and noisy receive pins.
        push_tx(5, 2);
        push_rx(4, 6);
        wait_idle();
        chk("R6", "mac_rx_valid after slow end", int'(mac_rx_valid), 0);

        // Transmit only: carrier must stay low.
        push_tx(4, 13);
        wait_idle();
        chk("R11", "mac_carrier after tx-only frame", int'(mac_carrier), 0);

        // Back to 100 Mbit/s, receive only.
        want_slow = 0;
        wait_idle();
        push_rx(6, 5);
        wait_idle();
        chk("R6", "mac_rx_valid after fast end", int'(mac_rx_valid), 0);

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        finish_run();
    end
endmodule